// File: doc/BRIEF.md
# Programmable Reference and Feedback Dividers for a Synthesizer Loop

This block holds the two integer counters that set the ratio of a frequency synthesizer loop. The reference divider reduces the reference clock to the compare rate and emits one pulse every `Q+2` reference edges. The feedback divider reduces the oscillator-side clock and emits one pulse every `2*(P+4)+Po` edges. `Po` is a single offset bit, so the feedback ratio can be odd as well as even. The loop then settles at `Fout = Fref * (2*(P+4)+Po) / (Q+2)`. The phase detector, the charge pump and the oscillator are outside this block.

Both dividers run in one clock domain. Each edge of the divided clock arrives as a one-cycle qualifier: `ref_tick` for the reference clock and `fb_tick` for the oscillator clock. A new `P`, `Q` and `Po` triple is presented on the configuration pins and captured by a one-cycle `cfg_load` strobe. Each divider adopts the captured value only when its own count runs out, so a divide period is never cut short. A spread modulator may rewrite `P` on every feedback period. The average output frequency then follows the time-averaged `P`. These are plain control pins; the block has no data stream and no back-pressure.

Top module: `pll_fracdiv_top`

## Requirements
- R1: While reset is held and in the first cycle after it, both pulse outputs are 0. Out of reset, the reference modulus is `RST_Q+2` and the feedback modulus is `2*(RST_P+4)+RST_PO`. With the defaults these are 2 and 8.
- R2: The reference divider emits exactly one pulse per `Q+2` asserted `ref_tick` cycles. `Q` is `cfg_q`, 7 bits, with a range of 0 to 127, giving moduli 2 to 129.
- R3: The feedback divider emits exactly one pulse per `2*(P+4)+Po` asserted `fb_tick` cycles. `P` is `cfg_p`, 10 bits, with a range of 0 to 1023.
- R4: `cfg_po` = 1 adds one to the feedback modulus, which gives odd ratios. `cfg_po` = 0 leaves the modulus even.
- R5: Each pulse is high for exactly one clock, in the cycle after the tick that reaches terminal count. No pulse follows a cycle without a tick.
- R6: A clock cycle with the tick low does not advance the corresponding counter. Periods are counted in ticks, not in clocks.
- R7: A value loaded in the middle of a period takes effect only after that divider's next terminal count. The period in progress completes with the old modulus, and the following periods use the new one.
- R8: `cfg_load` captures all three fields together. When several loads occur before a terminal count, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One reference clock edge this cycle |
| fb_tick | input | 1 | One oscillator clock edge this cycle |
| cfg_load | input | 1 | Capture strobe for cfg_p, cfg_q, cfg_po |
| cfg_p | input | 10 | Feedback count P |
| cfg_q | input | 7 | Reference count Q |
| cfg_po | input | 1 | Feedback offset bit |
| ref_pulse | output | 1 | Reference divider terminal pulse |
| fb_pulse | output | 1 | Feedback divider terminal pulse |

## Verification
The counters are swept through their extreme settings, with both Q and P at 0 and at full scale and Po at both values. Seeded pseudo-random settings follow, and the number of ticks between pulses is compared with the modulus computed from the formula. The sweeps separate an off-by-one in the base constants from a dropped offset bit or a truncated field. Runs with ticks gapped on alternate cycles distinguish counting ticks from counting clocks. Loads placed in the middle of a period, and doubled loads, show whether a new value truncates the current period or whether an older capture survives.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned FB_BASE  = 4;
  localparam int unsigned REF_BASE = 2;
  localparam int unsigned N_DIV    = 2;
  localparam int unsigned IDX_REF  = 0;
  localparam int unsigned IDX_FB   = 1;
endpackage

// File: rtl/pll_div_cfg.sv
module pll_div_cfg
  import pll_div_pkg::*;
#(
  parameter int unsigned P_W    = 10,
  parameter int unsigned Q_W    = 7,
  parameter int unsigned MW     = 12,
  parameter int unsigned RST_P  = 0,
  parameter int unsigned RST_Q  = 0,
  parameter bit          RST_PO = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [P_W-1:0] p_in,
  input  logic [Q_W-1:0] q_in,
  input  logic           po_in,
  output logic [MW-1:0]  ref_mod,
  output logic [MW-1:0]  fb_mod
);
  logic [P_W-1:0] pend_p;
  logic [Q_W-1:0] pend_q;
  logic           pend_po;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_p  <= P_W'(RST_P);
      pend_q  <= Q_W'(RST_Q);
      pend_po <= RST_PO;
    end else if (load) begin
      pend_p  <= p_in;
      pend_q  <= q_in;
      pend_po <= po_in;
    end
  end

  // moduli: Q+2 and 2*(P+4)+Po
  always_comb begin
    ref_mod = MW'(pend_q) + MW'(REF_BASE);
    fb_mod  = MW'({pend_p, 1'b0}) + MW'(2 * FB_BASE) + MW'(pend_po);
  end
endmodule

// File: rtl/pll_mod_div.sv
module pll_mod_div #(
  parameter int unsigned W       = 12,
  parameter int unsigned RST_MOD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] next_mod,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic         term;

  assign term = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= W'(RST_MOD - 1);
      pulse <= 1'b0;
    end else begin
      pulse <= term;
      if (term)      cnt <= next_mod - W'(1);
      else if (tick) cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/pll_fracdiv_top.sv
module pll_fracdiv_top
  import pll_div_pkg::*;
#(
  parameter int unsigned P_W    = 10,
  parameter int unsigned Q_W    = 7,
  parameter int unsigned RST_P  = 0,
  parameter int unsigned RST_Q  = 0,
  parameter bit          RST_PO = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_tick,
  input  logic           fb_tick,
  input  logic           cfg_load,
  input  logic [P_W-1:0] cfg_p,
  input  logic [Q_W-1:0] cfg_q,
  input  logic           cfg_po,
  output logic           ref_pulse,
  output logic           fb_pulse
);
  localparam int unsigned MW      = (P_W + 2 >= Q_W + 1) ? P_W + 2 : Q_W + 1;
  localparam int unsigned REF_RST = RST_Q + REF_BASE;
  localparam int unsigned FB_RST  = 2 * (RST_P + FB_BASE) + RST_PO;

  logic [MW-1:0]    mods [N_DIV];
  logic [N_DIV-1:0] ticks;
  logic [N_DIV-1:0] pulses;

  assign ticks[IDX_REF] = ref_tick;
  assign ticks[IDX_FB]  = fb_tick;

  pll_div_cfg #(
    .P_W(P_W), .Q_W(Q_W), .MW(MW),
    .RST_P(RST_P), .RST_Q(RST_Q), .RST_PO(RST_PO)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .p_in    (cfg_p),
    .q_in    (cfg_q),
    .po_in   (cfg_po),
    .ref_mod (mods[IDX_REF]),
    .fb_mod  (mods[IDX_FB])
  );

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    pll_mod_div #(
      .W       (MW),
      .RST_MOD ((g == IDX_REF) ? REF_RST : FB_RST)
    ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ticks[g]),
      .next_mod (mods[g]),
      .pulse    (pulses[g])
    );
  end

  assign ref_pulse = pulses[IDX_REF];
  assign fb_pulse  = pulses[IDX_FB];
endmodule

// File: rtl/pll_fracdiv_chk.sv
module pll_fracdiv_chk #(
  parameter int unsigned P_W = 10,
  parameter int unsigned Q_W = 7
) (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic fb_tick,
  input logic ref_pulse,
  input logic fb_pulse
);
  localparam int unsigned CW      = P_W + 3;
  localparam int unsigned REF_MAX = (1 << Q_W) + 1;
  localparam int unsigned FB_MAX  = 2 * ((1 << P_W) - 1 + 4) + 1;

  logic [CW-1:0] ref_cnt, fb_cnt;

  // ticks seen since the previous pulse, up to and including the terminal one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
    end else begin
      if (ref_pulse) ref_cnt <= CW'(ref_tick);
      else           ref_cnt <= ref_cnt + CW'(ref_tick);
      if (fb_pulse)  fb_cnt  <= CW'(fb_tick);
      else           fb_cnt  <= fb_cnt + CW'(fb_tick);
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!ref_pulse && !fb_pulse));

  p_ref_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_tick));

  p_fb_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> $past(fb_tick));

  p_ref_one_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  p_fb_one_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  p_ref_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> (ref_cnt >= CW'(2) && ref_cnt <= CW'(REF_MAX)));

  p_fb_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> (fb_cnt >= CW'(8) && fb_cnt <= CW'(FB_MAX)));
endmodule

bind pll_fracdiv_top pll_fracdiv_chk #(.P_W(P_W), .Q_W(Q_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_tick  (ref_tick),
  .fb_tick   (fb_tick),
  .ref_pulse (ref_pulse),
  .fb_pulse  (fb_pulse)
);

// File: tb/pll_fracdiv_top_tb.sv
`timescale 1ns/1ps
module pll_fracdiv_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0, fb_tick = 1'b0, cfg_load = 1'b0;
  logic [9:0] cfg_p = '0;
  logic [6:0] cfg_q = '0;
  logic       cfg_po = 1'b0;
  logic       ref_pulse, fb_pulse;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pll_fracdiv_top u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .cfg_load(cfg_load), .cfg_p(cfg_p), .cfg_q(cfg_q), .cfg_po(cfg_po),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
  );

  function automatic int fb_mod(int p, int po);
    return 2 * (p + 4) + po;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(int p, int q, int po);
    @(negedge clk);
    cfg_p = 10'(p); cfg_q = 7'(q); cfg_po = po[0]; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Drive ticks on one divider; sync on a pulse, then check nper intervals.
  // Interval 0 must equal exp_first, the others exp_rest. load_at >= 0
  // issues a load of (lp,lq,lpo) after that many ticks into interval 0.
  task automatic measure(bit fb, int exp_first, int exp_rest, int nper,
                         bit gap, int load_at, int lp, int lq, int lpo,
                         string req);
    int cnt = 0, seen = 0, iter = 0, bad_w = 0;
    bit synced = 0, prev_tick = 0, prev_pulse = 0, pl;
    while (seen < nper && iter < 20000) begin
      iter++;
      @(negedge clk);
      cfg_load = 1'b0;
      pl = fb ? fb_pulse : ref_pulse;
      if (pl && (!prev_tick || prev_pulse)) bad_w++;
      if (pl) begin
        if (synced) begin
          check(cnt == (seen == 0 ? exp_first : exp_rest), req, cnt,
                seen == 0 ? exp_first : exp_rest);
          seen++;
        end
        synced = 1; cnt = 0;
      end
      prev_pulse = pl;
      prev_tick = !(gap && iter[0]);
      if (synced && seen == 0 && cnt == load_at && load_at >= 0) begin
        cfg_p = 10'(lp); cfg_q = 7'(lq); cfg_po = lpo[0]; cfg_load = 1'b1;
      end
      if (fb) fb_tick = prev_tick; else ref_tick = prev_tick;
      if (prev_tick && synced) cnt++;
    end
    @(negedge clk);
    cfg_load = 1'b0; fb_tick = 1'b0; ref_tick = 1'b0;
    check(seen == nper, {req, " period count"}, seen, nper);
    check(bad_w == 0, "R5 pulse width/placement", bad_w, 0);
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed = 17;
    repeat (3) @(negedge clk);
    check(!ref_pulse && !fb_pulse, "R1 pulses low in reset", ref_pulse + fb_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ref_pulse && !fb_pulse, "R1 pulses low after reset", ref_pulse + fb_pulse, 0);
    // R1 reset moduli
    measure(0, 2, 2, 3, 0, -1, 0, 0, 0, "R1 reset ref modulus");
    measure(1, 8, 8, 3, 0, -1, 0, 0, 0, "R1 reset fb modulus");
    // R2 / R3 / R4 limits
    load_cfg(1023, 127, 1);
    measure(0, 129, 129, 2, 0, -1, 0, 0, 0, "R2 Q=127");
    measure(1, 2055, 2055, 2, 0, -1, 0, 0, 0, "R3 R4 P=1023 Po=1");
    load_cfg(1023, 1, 0);
    measure(1, 2054, 2054, 2, 0, -1, 0, 0, 0, "R3 R4 P=1023 Po=0");
    measure(0, 3, 3, 3, 0, -1, 0, 0, 0, "R2 Q=1");
    load_cfg(0, 0, 1);
    measure(1, 9, 9, 3, 0, -1, 0, 0, 0, "R4 P=0 Po=1 odd");
    measure(0, 2, 2, 3, 0, -1, 0, 0, 0, "R2 Q=0");
    // R6 gapped ticks
    load_cfg(5, 9, 1);
    measure(1, fb_mod(5, 1), fb_mod(5, 1), 3, 1, -1, 0, 0, 0, "R6 fb gapped");
    measure(0, 11, 11, 3, 1, -1, 0, 0, 0, "R6 ref gapped");
    // R7 mid-period loads
    measure(1, fb_mod(5, 1), fb_mod(40, 0), 3, 0, 6, 40, 20, 0, "R7 fb mid-period load");
    measure(0, 22, 22, 2, 0, -1, 0, 0, 0, "R7 ref after load");
    measure(0, 22, 50, 3, 0, 4, 7, 48, 1, "R7 ref mid-period load");
    // R8 last load wins
    load_cfg(100, 30, 0);
    load_cfg(3, 12, 1);
    measure(1, fb_mod(3, 1), fb_mod(3, 1), 2, 0, -1, 0, 0, 0, "R8 fb last load");
    measure(0, 14, 14, 2, 0, -1, 0, 0, 0, "R8 ref last load");
    // R2 / R3 pseudo-random settings
    for (int i = 0; i < 6; i++) begin
      int p, q, po;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      p  = (seed >> 4) % 1024;
      q  = (seed >> 14) % 128;
      po = (seed >> 21) & 1;
      load_cfg(p, q, po);
      measure(1, fb_mod(p, po), fb_mod(p, po), 2, i[0], -1, 0, 0, 0, "R3 random fb");
      measure(0, q + 2, q + 2, 2, i[0], -1, 0, 0, 0, "R2 random ref");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule